// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is a small register-transfer datapath: four general registers, an address register and a sixteen-word memory, all joined by one bus. The bus is a tree of multiplexers, one per bit, steered by a 2-bit source code. It is not built from three-state drivers. Each register sees the bus at its input and captures it on a rising clock edge only when its own load line and the common transfer enable are both high. Because the bus reaches every register, one source can be copied into several destinations on the same edge.

The memory is addressed by the address register. A read places the addressed word on the bus in the same cycle, so a read followed by a load completes in one clock. A write stores the selected register at the addressed word on the clock edge. An external data word can also be placed on the bus, and this is the only way values enter the datapath. All steering comes from outside the block; the block does no instruction decoding or sequencing.

Top module: `regbus_datapath`

## Requirements
- R1: An active-high synchronous reset clears the four registers and the address register to zero at the next rising edge.
- R2: With no memory access and no external drive, `bus_q` carries the register whose code is on `src_sel`: 0 = A, 1 = B, 2 = C, 3 = D. Register k is `reg_q[4k+3:4k]`.
- R3: When `xfer_en` is high and `load_en[k]` is high, register k takes the value of `bus_q` at the rising edge. When `ext_sel` is high and the memory is idle, the bus carries `ext_data`.
- R4: A register whose `load_en` bit is low keeps its contents across the edge, whatever the bus carries.
- R5: Several `load_en` bits may be high at once, and every selected register takes the same bus value on that edge.
- R6: When `xfer_en` is low, no register, the address register and no memory word changes, whatever the load, address-load and write inputs are.
- R7: With `xfer_en` and `addr_load` high, the address register takes the bus value at the edge.
- R8: With `xfer_en` and `mem_wr` high, the register picked by `src_sel` is stored in the memory word named by the address register.
- R9: With `mem_rd` high and `mem_wr` low, `bus_q` carries the addressed memory word in the same cycle, and a loaded register holds that word after the edge.
- R10: If `mem_rd` and `mem_wr` are both high, the write wins: the bus carries the selected register, the write takes place, and loaded registers take that register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | Control function that gates every state change |
| src_sel | input | 2 | Register code that drives the bus |
| ext_sel | input | 1 | Places `ext_data` on the bus |
| ext_data | input | 4 | External word for the bus |
| load_en | input | 4 | Per-register load lines, bit k for code k |
| addr_load | input | 1 | Load line of the address register |
| mem_rd | input | 1 | Memory word drives the bus |
| mem_wr | input | 1 | Store the selected register to memory |
| bus_q | output | 4 | Current bus value |
| reg_q | output | 16 | The four registers, register k in bits 4k+3:4k |
| addr_q | output | 4 | Address register |

## Verification
The bus is combinational. It is due in the same cycle as its select, read and external-drive inputs, so the bench drives on the falling edge and compares `bus_q` one nanosecond later, before the next rising edge. Register, address and memory effects are due at the first rising edge after the stimulus. The bench compares `reg_q` and `addr_q` one nanosecond after that edge. Memory contents are checked later, when a read puts the stored word back on the bus. A bench model updated from the requirements supplies every expected value.

// File: rtl/regbus_datapath.sv
module regbus_datapath #(
  parameter int W     = 4,
  parameter int SEL_W = 2,
  localparam int NREG  = 1 << SEL_W,
  localparam int DEPTH = 1 << W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_en,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic              ext_sel,
  input  logic [W-1:0]      ext_data,
  input  logic [NREG-1:0]   load_en,
  input  logic              addr_load,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic [W-1:0]      bus_q,
  output logic [NREG*W-1:0] reg_q,
  output logic [W-1:0]      addr_q
);

  logic [W-1:0]    regs [NREG];
  logic [W-1:0]    mem  [DEPTH];
  logic [NREG-1:0] slice [W];
  logic [W-1:0]    reg_bus;

  // one multiplexer per bus bit, input k fed by register k
  for (genvar b = 0; b < W; b++) begin : g_bit
    for (genvar k = 0; k < NREG; k++) begin : g_src
      assign slice[b][k] = regs[k][b];
    end
    assign reg_bus[b] = slice[b][src_sel];
  end

  assign bus_q = mem_wr  ? reg_bus      :
                 mem_rd  ? mem[addr_q]  :
                 ext_sel ? ext_data     : reg_bus;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                         regs[k] <= '0;
      else if (xfer_en && load_en[k])  regs[k] <= bus_q;
    end
    assign reg_q[k*W +: W] = regs[k];

    // R4
    unloaded_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load_en[k] |=> $stable(reg_q[k*W +: W]));

    // R3
    reg_source_load_chk: assert property (@(posedge clk) disable iff (rst)
      (xfer_en && load_en[k] && (mem_wr || (!mem_rd && !ext_sel)))
        |=> reg_q[k*W +: W] == $past(reg_q[src_sel*W +: W]));
  end

  always_ff @(posedge clk) begin
    if (rst)                       addr_q <= '0;
    else if (xfer_en && addr_load) addr_q <= bus_q;
  end

  always_ff @(posedge clk) begin
    if (xfer_en && mem_wr) mem[addr_q] <= reg_bus;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (reg_q == '0 && addr_q == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |=> ($stable(reg_q) && $stable(addr_q)));

  // R7
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && addr_load && !mem_rd && !mem_wr && ext_sel)
      |=> addr_q == $past(ext_data));

  // R10
  write_priority_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> bus_q == reg_q[src_sel*W +: W]);

endmodule

// File: tb/regbus_datapath_bench.sv
module regbus_datapath_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        xfer_en = 0;
  logic [1:0]  src_sel = 0;
  logic        ext_sel = 0;
  logic [3:0]  ext_data = 0;
  logic [3:0]  load_en = 0;
  logic        addr_load = 0;
  logic        mem_rd = 0;
  logic        mem_wr = 0;
  logic [3:0]  bus_q;
  logic [15:0] reg_q;
  logic [3:0]  addr_q;

  logic [3:0] m_reg [4];
  logic [3:0] m_mem [16];
  logic [3:0] m_addr;
  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  regbus_datapath u_regbus_datapath (
    .clk(clk), .rst(rst), .xfer_en(xfer_en), .src_sel(src_sel),
    .ext_sel(ext_sel), .ext_data(ext_data), .load_en(load_en),
    .addr_load(addr_load), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .bus_q(bus_q), .reg_q(reg_q), .addr_q(addr_q));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] packed_regs();
    return {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
  endfunction

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1; xfer_en = 0; load_en = 0; addr_load = 0; mem_rd = 0; mem_wr = 0; ext_sel = 0;
    @(posedge clk); #1;
    rst = 0;
    for (int k = 0; k < 4; k++) m_reg[k] = 0;
    m_addr = 0;
    check(tag, reg_q, 16'h0);
    check(tag, {12'h0, addr_q}, 16'h0);
  endtask

  task automatic step(input string tag, input logic xf, input logic [1:0] sel,
                      input logic ex, input logic [3:0] d, input logic [3:0] ld,
                      input logic al, input logic rd, input logic wr);
    logic [3:0] eb;
    logic [3:0] nreg [4];
    logic [3:0] naddr;
    @(negedge clk);
    xfer_en = xf; src_sel = sel; ext_sel = ex; ext_data = d;
    load_en = ld; addr_load = al; mem_rd = rd; mem_wr = wr;
    #1;
    eb = wr ? m_reg[sel] : rd ? m_mem[m_addr] : ex ? d : m_reg[sel];
    check({tag, " bus"}, {12'h0, bus_q}, {12'h0, eb});
    for (int k = 0; k < 4; k++) nreg[k] = (xf && ld[k]) ? eb : m_reg[k];
    naddr = (xf && al) ? eb : m_addr;
    if (xf && wr) m_mem[m_addr] = m_reg[sel];
    for (int k = 0; k < 4; k++) m_reg[k] = nreg[k];
    m_addr = naddr;
    @(posedge clk); #1;
    check({tag, " regs"}, reg_q, packed_regs());
    check({tag, " addr"}, {12'h0, addr_q}, {12'h0, m_addr});
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    do_reset("R1 initial");
    // R3: each register from the external word
    for (int k = 0; k < 4; k++)
      step("R3", 1, 2'(k), 1, 4'((k * 5 + 3) & 15), 4'(1 << k), 0, 0, 0);
    // R2: every source code onto the bus
    for (int s = 0; s < 4; s++) step("R2", 1, 2'(s), 0, 0, 0, 0, 0, 0);
    // R4 / R5: every load mask
    for (int m = 0; m < 16; m++) begin
      step("R4", 1, 0, 1, 4'(m ^ 10), ~4'(m), 0, 0, 0);
      step("R5", 1, 2'(m % 4), 0, 0, 4'(m), 0, 0, 0);
    end
    // R6: control function low blocks everything
    for (int m = 0; m < 4; m++) step("R6", 0, 2'(m), 1, 4'(m + 9), 4'hF, 1, 0, 1);
    // R7 / R8: address every word and store into it
    for (int a = 0; a < 16; a++) begin
      step("R7", 1, 0, 1, 4'(a), 0, 1, 0, 0);
      step("R8 setup", 1, 0, 1, 4'((a * 7 + 1) & 15), 4'(1 << (a % 4)), 0, 0, 0);
      step("R8", 1, 2'(a % 4), 0, 0, 0, 0, 0, 1);
    end
    // R9: read every word onto the bus into a register
    for (int a = 0; a < 16; a++) begin
      step("R9 addr", 1, 0, 1, 4'(a), 0, 1, 0, 0);
      step("R9", 1, 0, 0, 0, 4'(1 << ((a + 1) % 4)), 0, 1, 0);
    end
    // R6: a write with xfer_en low leaves memory unchanged
    step("R6 addr", 1, 0, 1, 4'd5, 0, 1, 0, 0);
    step("R6 setup", 1, 0, 1, 4'hF, 4'b0001, 0, 0, 0);
    step("R6 memwr", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R6 readback", 1, 0, 0, 0, 4'b0010, 0, 1, 0);
    // R10: read and write together, the write wins
    step("R10 addr", 1, 0, 1, 4'd3, 0, 1, 0, 0);
    step("R10 setup", 1, 0, 1, 4'h9, 4'b0010, 0, 0, 0);
    step("R10", 1, 2'd1, 0, 0, 4'b0100, 0, 1, 1);
    step("R10 readback", 1, 0, 0, 0, 4'b1000, 0, 1, 0);
    do_reset("R1 midrun");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule